// File: doc/BRIEF.md
# Serial Byte Memory Target with Write Locking

This block is a two-wire serial bus target that behaves as a 256-byte byte-addressed memory. It runs on a system clock. The bus clock and data lines are sampled through synchronising flops and treated as slow signals. Start and stop conditions are recognised from their edges. The block compares the device select byte against a fixed type nibble and three strap inputs. A master can then load the word pointer and store bytes, or it can read bytes back one after another with the pointer advancing on each byte.

Writes are gated in two ways. A hardware lock input refuses every store, including any change to the lock register. A one-bit lock register, reached through a second type nibble, can also fence off the lower half of the array. That register only sets. It clears on a system reset or while the power-good input is low. While power-good is low the whole block is held in reset and ignores the bus. The array contents are not cleared by this reset.

There is no streaming data port. The serial bus is the only data path, and the bus master paces every transfer through its clock, so there is no back-pressure at the block's edge. All other pins are plain levels.

Top module: `i2c_mem_slave`

## Requirements
- R1: A select byte is acknowledged only if its bits 7:4 are 4'b1010 (array) or 4'b0110 with bit 0 low (lock register), and its bits 3:1 equal chip_sel. For any other select byte the target gives no acknowledge and stays silent until the next START.
- R2: In a write transfer (array select with bit 0 low), the byte after the select byte loads the word pointer. Each later byte is stored at the pointer, and the pointer then advances by one modulo 256. Every one of these bytes is acknowledged.
- R3: A read select (array select with bit 0 high) returns the byte at the pointer, MSB first, and advances the pointer. A repeated START after a written address gives a random read. Each master acknowledge (data line low) fetches the next byte, with the pointer wrapping from 255 to 0. A master no-acknowledge ends the read, and the target releases the line.
- R4: While wr_lock is high, no array byte and no lock register bit changes. Write bytes are still acknowledged.
- R5: A data byte with bit 0 high, sent after a lock register select while wr_lock is low, sets the lock. A byte with bit 0 low leaves it unchanged. Once set, the lock stays set until rst_n or pwr_ok goes low.
- R6: With the lock set and wr_lock low, stores to addresses 0x00 to 0x7F are acknowledged but discarded, and stores to 0x80 to 0xFF take effect.
- R7: While pwr_ok is low the target gives no acknowledge and never pulls the line. Coming out of that state, the lock is clear and the array contents are kept.
- R8: sda_pull high means the data line is pulled low. The target never drives the line high. It only starts pulling after a falling edge of the bus clock, and only in its acknowledge bits or in 0 bits that it transmits.
- R9: A STOP at any point returns the target to idle, and a partly received byte is dropped unwritten. A START at any point begins a new select phase.
- R10: After reset, sda_pull is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| pwr_ok | input | 1 | Power-good; low holds the block in reset |
| chip_sel | input | 3 | Strap value matched against select bits 3:1 |
| wr_lock | input | 1 | High refuses all stores |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull | output | 1 | High pulls the data line low (open drain) |

## Verification
The assertions watch, on every cycle, the properties that can be seen at a single edge. Under power-down the line stays released. No store or lock update happens while wr_lock is high. The lock never clears on its own. No lower-half store happens while locked. A new pull only follows a bus clock fall, and the line is released after a STOP. Select matching, the data that comes back from a read, pointer wrap, acknowledge values, aborts part way through a byte, and memory that survives power-down can only be shown by the bench's bus scenarios. In those scenarios a behavioural memory model predicts every read byte and every acknowledge.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} bus_state_t;
  typedef enum logic [1:0] {PH_SEL, PH_ADDR, PH_WDATA, PH_LOCK} phase_t;
  localparam logic [3:0] ARRAY_TAG = 4'b1010;
  localparam logic [3:0] LOCK_TAG  = 4'b0110;
endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic run,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_prev, sda_prev, scl_s;

  always_ff @(posedge clk) begin
    if (!run) begin
      scl_ff   <= '1;
      sda_ff   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[SYNC_N-2:0], scl_in};
      sda_ff   <= {sda_ff[SYNC_N-2:0], sda_in};
      scl_prev <= scl_s;
      sda_prev <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          run,
  input  logic          mem_we,
  input  logic          prot_we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          prot_q
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!run)         prot_q <= 1'b0;
    else if (prot_we) prot_q <= 1'b1;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/i2c_mem_ctrl.sv
module i2c_mem_ctrl
  import i2c_mem_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          run,
  input  logic [2:0]    chip_sel,
  input  logic          wr_lock,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [7:0]    rdata,
  input  logic          prot_q,
  output logic          mem_we,
  output logic          prot_we,
  output logic [AW-1:0] ptr,
  output logic [7:0]    wdata,
  output logic          sda_pull
);
  localparam logic [3:0] BITS = 4'd8;
  localparam logic [3:0] LAST = 4'd7;

  bus_state_t state;
  phase_t     phase;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rd_mode, mack_ok;
  logic       byte_end, sel_array, sel_lock, take;

  assign byte_end  = (state == ST_RX) && (cnt == BITS) && scl_fall;
  assign sel_array = (sh[7:4] == ARRAY_TAG) && (sh[3:1] == chip_sel);
  assign sel_lock  = (sh[7:4] == LOCK_TAG) && (sh[3:1] == chip_sel) && !sh[0];
  assign take      = (phase != PH_SEL) || sel_array || sel_lock;
  assign mem_we    = byte_end && (phase == PH_WDATA) && !wr_lock
                     && !(prot_q && !ptr[AW-1]);
  assign prot_we   = byte_end && (phase == PH_LOCK) && !wr_lock && sh[0];
  assign wdata     = sh;
  assign sda_pull  = (state == ST_ACK) || ((state == ST_TX) && !sh[7]);

  always_ff @(posedge clk) begin
    if (!run) begin
      state   <= ST_IDLE;
      phase   <= PH_SEL;
      cnt     <= '0;
      sh      <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
    end else if (start_det) begin
      state <= ST_RX;
      phase <= PH_SEL;
      cnt   <= '0;
    end else if (stop_det) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && cnt != BITS) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end
          if (byte_end) begin
            state <= take ? ST_ACK : ST_IDLE;
            case (phase)
              PH_SEL: begin
                phase   <= sel_lock ? PH_LOCK : PH_ADDR;
                rd_mode <= sel_array && sh[0];
              end
              PH_ADDR: begin
                ptr   <= sh[AW-1:0];
                phase <= PH_WDATA;
              end
              PH_WDATA: ptr <= ptr + 1'b1;
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rd_mode) begin
              sh    <= rdata;
              ptr   <= ptr + 1'b1;
              state <= ST_TX;
            end else begin
              state <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              state <= ST_MACK;
            end else begin
              sh  <= {sh[6:0], 1'b0};
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_ok <= !sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              sh    <= rdata;
              ptr   <= ptr + 1'b1;
              cnt   <= '0;
              state <= ST_TX;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int ADDR_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic [2:0] chip_sel,
  input  logic       wr_lock,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull
);
  logic run;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic mem_we, prot_we, prot_q;
  logic [ADDR_W-1:0] ptr;
  logic [7:0] wdata, rdata;

  assign run = rst_n & pwr_ok;

  i2c_mem_sync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .run(run), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_mem_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk(clk), .run(run), .chip_sel(chip_sel), .wr_lock(wr_lock),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rdata(rdata),
    .prot_q(prot_q), .mem_we(mem_we), .prot_we(prot_we), .ptr(ptr),
    .wdata(wdata), .sda_pull(sda_pull)
  );

  i2c_mem_store #(.AW(ADDR_W)) u_store (
    .clk(clk), .run(run), .mem_we(mem_we), .prot_we(prot_we),
    .addr(ptr), .wdata(wdata), .rdata(rdata), .prot_q(prot_q)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_ok,
  input logic          wr_lock,
  input logic          sda_pull,
  input logic          mem_we,
  input logic          prot_we,
  input logic          prot_q,
  input logic [AW-1:0] ptr,
  input logic          scl_fall,
  input logic          stop_det
);
  // R7
  por_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> !sda_pull);

  // R4
  hw_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |-> !(mem_we || prot_we));

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_ok)
    prot_q |=> prot_q);

  // R6
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && mem_we) |-> ptr[AW-1]);

  // R8
  pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_ok)
    $rose(sda_pull) |-> $past(scl_fall));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .wr_lock(wr_lock),
  .sda_pull(sda_pull), .mem_we(mem_we), .prot_we(prot_we), .prot_q(prot_q),
  .ptr(ptr), .scl_fall(scl_fall), .stop_det(stop_det)
);

// File: tb/i2c_mem_slave_test.sv
`timescale 1ns/1ps
module i2c_mem_slave_test;
  localparam int H = 10;
  localparam logic [2:0] CS     = 3'b101;
  localparam logic [7:0] DEV_W  = 8'hAA;
  localparam logic [7:0] DEV_R  = 8'hAB;
  localparam logic [7:0] LOCK_W = 8'h6A;
  localparam logic [7:0] BAD_W  = 8'hA8;
  localparam logic [7:0] BAD_T  = 8'hCA;
  typedef logic [7:0] bq_t[$];

  logic clk = 0, rst_n = 0, pwr_ok = 1, wr_lock = 0, scl_m = 1, sda_m = 1;
  logic [2:0] chip_sel = CS;
  logic sda_pull, sda_bus;
  int checks = 0, errors = 0;
  logic [7:0] ref_mem [256];
  bit ref_prot = 0, slave_silent = 1, done = 0;
  string mon_req = "R8";

  assign sda_bus = sda_m & ~sda_pull;
  always #10 clk = ~clk;

  i2c_mem_slave uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .chip_sel(chip_sel),
    .wr_lock(wr_lock), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison: while SCL is high and the model says the target is silent
  always @(negedge clk) begin
    if (rst_n && scl_m && slave_silent) begin
      checks++;
      if (sda_pull) begin
        errors++;
        $display("FAIL %s: got pull 1 expected 0 at %0t", mon_req, $time);
      end
    end
  end

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_c();
    slave_silent = 1; sda_m = 1; wt(H/2);
    scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(H/2);
  endtask

  task automatic stop_c();
    slave_silent = 1; sda_m = 0; wt(H/2);
    scl_m = 1; wt(H); sda_m = 1; wt(H);
  endtask

  task automatic wbit(logic b);
    slave_silent = 1; sda_m = b; wt(H/2);
    scl_m = 1; wt(H); scl_m = 0; wt(H/2);
  endtask

  task automatic rbit(bit from_slave, output logic b);
    slave_silent = !from_slave; sda_m = 1; wt(H/2);
    scl_m = 1; wt(H/2); b = sda_bus; wt(H/2); scl_m = 0; wt(H/2);
  endtask

  task automatic send_byte(logic [7:0] v, bit exp_ack, string req);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(exp_ack, a);
    check(req, int'(!a), int'(exp_ack));
  endtask

  task automatic recv_byte(logic [7:0] exp, bit last, string req);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(1, b); v[i] = b; end
    check(req, v, exp);
    wbit(last);
  endtask

  task automatic ref_store(logic [7:0] a, logic [7:0] d);
    if (!wr_lock && !(ref_prot && a < 8'h80)) ref_mem[a] = d;
  endtask

  task automatic wr_seq(logic [7:0] a, bq_t q, string req);
    logic [7:0] p;
    start_c();
    send_byte(DEV_W, 1, "R1");
    send_byte(a, 1, req);
    p = a;
    foreach (q[i]) begin
      send_byte(q[i], 1, req);
      ref_store(p, q[i]);
      p++;
    end
    stop_c();
  endtask

  task automatic rd_seq(logic [7:0] a, int n, string req);
    logic [7:0] p;
    start_c();
    send_byte(DEV_W, 1, "R1");
    send_byte(a, 1, req);
    start_c();
    send_byte(DEV_R, 1, "R3");
    p = a;
    for (int k = 0; k < n; k++) begin
      recv_byte(ref_mem[p], k == n - 1, req);
      p++;
    end
    stop_c();
  endtask

  task automatic lock_seq(logic [7:0] d);
    start_c();
    send_byte(LOCK_W, 1, "R5");
    send_byte(d, 1, "R5");
    stop_c();
    if (!wr_lock && d[0]) ref_prot = 1;
  endtask

  initial begin
    wt(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wt(5);
    rst_n = 1;
    wt(5);
    check("R10", sda_pull, 0);

    // R2 R3: single write and random read
    wr_seq(8'h10, '{8'h5A}, "R2");
    rd_seq(8'h10, 1, "R3");

    // R2 R3: multi-byte write and sequential read across the wrap
    wr_seq(8'hFE, '{8'h11, 8'h22, 8'h33}, "R2");
    rd_seq(8'hFE, 3, "R3");

    // R1: strap mismatch and wrong type nibble are not acknowledged
    mon_req = "R1";
    start_c(); send_byte(BAD_W, 0, "R1"); send_byte(8'h10, 0, "R1"); stop_c();
    start_c(); send_byte(BAD_T, 0, "R1"); stop_c();
    mon_req = "R8";
    rd_seq(8'h10, 1, "R1");

    // R9: STOP and START in the middle of a data byte
    wr_seq(8'h20, '{8'h99}, "R9");
    wr_seq(8'h7F, '{8'h01}, "R9");
    start_c(); send_byte(DEV_W, 1, "R9"); send_byte(8'h20, 1, "R9");
    wbit(0); wbit(1); wbit(1); wbit(0);
    stop_c();
    start_c(); send_byte(DEV_W, 1, "R9"); send_byte(8'h20, 1, "R9");
    wbit(0); wbit(0); wbit(1);
    wr_seq(8'h30, '{8'h5C}, "R9");
    rd_seq(8'h20, 1, "R9");
    rd_seq(8'h30, 1, "R9");

    // R4: hardware lock refuses array and register stores
    wr_lock = 1;
    wr_seq(8'h10, '{8'hFF}, "R4");
    lock_seq(8'h01);
    wr_lock = 0;
    rd_seq(8'h10, 1, "R4");
    wr_seq(8'h11, '{8'h12}, "R4");
    rd_seq(8'h11, 1, "R4");

    // R5: bit0 low leaves lock clear, bit0 high sets it
    lock_seq(8'hFE);
    wr_seq(8'h12, '{8'h34}, "R5");
    rd_seq(8'h12, 1, "R5");
    lock_seq(8'h01);

    // R6: lower half refused, upper half written, boundary 7F/80
    wr_seq(8'h10, '{8'h77}, "R6");
    wr_seq(8'h7F, '{8'hAB, 8'hCD}, "R6");
    wr_seq(8'h90, '{8'h44}, "R6");
    rd_seq(8'h7F, 2, "R6");
    rd_seq(8'h10, 1, "R6");
    rd_seq(8'h90, 1, "R6");

    // R7: power-down ignores the bus, clears the lock, keeps the array
    pwr_ok = 0;
    wt(4);
    check("R7", sda_pull, 0);
    mon_req = "R7";
    start_c(); send_byte(DEV_W, 0, "R7"); send_byte(8'h10, 0, "R7"); stop_c();
    mon_req = "R8";
    pwr_ok = 1;
    ref_prot = 0;
    wt(10);
    rd_seq(8'h90, 1, "R7");
    wr_seq(8'h10, '{8'h66}, "R7");
    rd_seq(8'h10, 1, "R7");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule